// File: doc/BRIEF.md
# Privileged Mode Instruction Gate

This block sits beside the instruction decoder and rules on each decoded instruction. It decides whether one of the special system-management instructions may proceed, or whether the instruction must be turned into an invalid-opcode fault. The decoder presents an opcode class with a valid strobe. The ruling draws on the current privilege level, a 4-bit size field of the protected region and three configuration bits: a mode enable, an access-control bit and a feature enable.

One of the conditions can be met in two ways: by the access-control bit, or by the fact that the processor is running inside the service routine. The block tracks that second fact itself, setting a flag on an entry-complete pulse and clearing it on a resume pulse. The gated instructions carry no address condition, so they may run outside the region's address space.

The allow output is combinational, so the decoder can act on it in the cycle the instruction is presented. The fault output is a registered one-cycle pulse in the next cycle.

Top module: `priv_op_gate`

## Requirements
- R1: After synchronous reset, `in_handler` is 0 and `op_fault` is 0.
- R2: Opcode classes outside 1 to 10 (class 0 and classes 11 to 15) are not gated. With `op_valid` high they give `op_allow` = 1, and `op_fault` stays 0 in the following cycle.
- R3: A gated class (1 to 10) is allowed only when `region_size` is nonzero.
- R4: A gated class other than 7 is allowed only when `cpl` equals 0.
- R5: A gated class other than 7 is allowed only when `cfg_acc_ctl` is 1 or `in_handler` is 1. With all other conditions met, either one of them is enough.
- R6: A gated class is allowed only when both `cfg_mode_en` and `cfg_feat_en` are 1.
- R7: Class 7 (software entry) is allowed exactly when `region_size` is nonzero, `cfg_mode_en` is 1, `cfg_feat_en` is 1 and `cfg_acc_ctl` is 1. Neither `cpl` nor `in_handler` affects it.
- R8: When a gated class is presented with `op_valid` high and is not allowed, `op_fault` is 1 for exactly the next cycle. Otherwise `op_fault` is 0.
- R9: `in_handler` becomes 1 the cycle after `entry_done` is high, and 0 the cycle after `resume_done` is high while `entry_done` is low. If both are high together, entry wins.
- R10: With `op_valid` low, `op_allow` is 0 and no fault follows, whatever the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Decoded instruction present |
| op_class | input | 4 | Opcode class (1..10 gated, 7 = software entry, 8 = resume) |
| cpl | input | 2 | Current privilege level |
| region_size | input | 4 | Protected-region size field |
| cfg_mode_en | input | 1 | Mode-enable configuration bit |
| cfg_acc_ctl | input | 1 | Access-control configuration bit |
| cfg_feat_en | input | 1 | Feature-enable configuration bit |
| entry_done | input | 1 | One-cycle pulse: service routine entered |
| resume_done | input | 1 | One-cycle pulse: service routine left |
| op_allow | output | 1 | Instruction may execute (same cycle) |
| op_fault | output | 1 | Invalid-opcode fault pulse (next cycle) |
| in_handler | output | 1 | Service routine active |

## Verification
`op_allow` is combinational, so the bench samples it 1 ns after driving the inputs at the falling edge, within the same cycle. `op_fault` passes through one register. The bench therefore keeps each instruction's expected fault and compares it at the next falling edge, just as it drives the next instruction. `in_handler` is also registered, so it is checked one falling edge after the entry or resume pulse. The main sweep covers every class, privilege level, size value and configuration combination, both with and without the handler active, one instruction per cycle.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

    localparam int PG_CLS_W = 4;
    localparam int PG_SZ_W  = 4;
    localparam int PG_PL_W  = 2;

    typedef enum logic [PG_CLS_W-1:0] {
        CLS_PLAIN     = 4'd0,
        CLS_SAVE_DESC = 4'd1,
        CLS_LOAD_DESC = 4'd2,
        CLS_SAVE_LTAB = 4'd3,
        CLS_LOAD_LTAB = 4'd4,
        CLS_SAVE_TASK = 4'd5,
        CLS_LOAD_TASK = 4'd6,
        CLS_SW_ENTRY  = 4'd7,
        CLS_RESUME    = 4'd8,
        CLS_HDR_RD    = 4'd9,
        CLS_HDR_WR    = 4'd10
    } op_class_e;

    localparam logic [PG_CLS_W-1:0] CLS_GATED_LO = CLS_SAVE_DESC;
    localparam logic [PG_CLS_W-1:0] CLS_GATED_HI = CLS_HDR_WR;

    typedef struct packed {
        logic gated;
        logic sw_entry;
        logic permit;
    } gate_verdict_t;

    function automatic logic cls_is_gated(input logic [PG_CLS_W-1:0] c);
        return (c >= CLS_GATED_LO) && (c <= CLS_GATED_HI);
    endfunction

    function automatic logic cls_is_sw_entry(input logic [PG_CLS_W-1:0] c);
        return c == CLS_SW_ENTRY;
    endfunction

endpackage

// File: rtl/pg_handler_track.sv
module pg_handler_track (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic leave,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst)        active <= 1'b0;
        else if (enter) active <= 1'b1;
        else if (leave) active <= 1'b0;
    end
endmodule

// File: rtl/pg_cond_eval.sv
module pg_cond_eval
    import priv_gate_pkg::*;
#(
    parameter int CLS_W = PG_CLS_W,
    parameter int SZ_W  = PG_SZ_W,
    parameter int PL_W  = PG_PL_W
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [PL_W-1:0]  cpl,
    input  logic [SZ_W-1:0]  size,
    input  logic             mode_en,
    input  logic             acc_ctl,
    input  logic             feat_en,
    input  logic             in_hdl,
    output gate_verdict_t    verdict
);
    localparam logic [PL_W-1:0] RING0 = '0;

    logic region_ok, enables_ok, ring_ok, access_ok;

    always_comb begin
        region_ok  = |size;
        enables_ok = mode_en & feat_en;
        ring_ok    = (cpl == RING0);
        access_ok  = acc_ctl | in_hdl;

        verdict.gated    = cls_is_gated(cls);
        verdict.sw_entry = cls_is_sw_entry(cls);
        if (verdict.sw_entry)
            verdict.permit = region_ok & enables_ok & acc_ctl;
        else
            verdict.permit = region_ok & enables_ok & ring_ok & access_ok;
    end
endmodule

// File: rtl/pg_fault_reg.sv
module pg_fault_reg
    import priv_gate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  gate_verdict_t verdict,
    output logic          fault
);
    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= valid & verdict.gated & ~verdict.permit;
    end
endmodule

// File: rtl/priv_op_gate.sv
module priv_op_gate
    import priv_gate_pkg::*;
#(
    parameter int CLS_W = PG_CLS_W,
    parameter int SZ_W  = PG_SZ_W,
    parameter int PL_W  = PG_PL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [CLS_W-1:0] op_class,
    input  logic [PL_W-1:0]  cpl,
    input  logic [SZ_W-1:0]  region_size,
    input  logic             cfg_mode_en,
    input  logic             cfg_acc_ctl,
    input  logic             cfg_feat_en,
    input  logic             entry_done,
    input  logic             resume_done,
    output logic             op_allow,
    output logic             op_fault,
    output logic             in_handler
);
    gate_verdict_t verdict;

    pg_handler_track u_track (
        .clk    (clk),
        .rst    (rst),
        .enter  (entry_done),
        .leave  (resume_done),
        .active (in_handler)
    );

    pg_cond_eval #(.CLS_W(CLS_W), .SZ_W(SZ_W), .PL_W(PL_W)) u_eval (
        .cls     (op_class),
        .cpl     (cpl),
        .size    (region_size),
        .mode_en (cfg_mode_en),
        .acc_ctl (cfg_acc_ctl),
        .feat_en (cfg_feat_en),
        .in_hdl  (in_handler),
        .verdict (verdict)
    );

    pg_fault_reg u_fault (
        .clk     (clk),
        .rst     (rst),
        .valid   (op_valid),
        .verdict (verdict),
        .fault   (op_fault)
    );

    assign op_allow = op_valid & (~verdict.gated | verdict.permit);
endmodule

// File: rtl/pg_gate_checker.sv
module pg_gate_checker
    import priv_gate_pkg::*;
#(
    parameter int CLS_W = PG_CLS_W,
    parameter int SZ_W  = PG_SZ_W,
    parameter int PL_W  = PG_PL_W
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [CLS_W-1:0] op_class,
    input logic [PL_W-1:0]  cpl,
    input logic [SZ_W-1:0]  region_size,
    input logic             cfg_mode_en,
    input logic             cfg_acc_ctl,
    input logic             cfg_feat_en,
    input logic             entry_done,
    input logic             resume_done,
    input logic             op_allow,
    input logic             op_fault,
    input logic             in_handler
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!op_fault && !in_handler));

    assert_plain_passes_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !cls_is_gated(op_class)) |-> op_allow);

    assert_region_needed_R3: assert property (@(posedge clk) disable iff (rst)
        (op_allow && cls_is_gated(op_class)) |-> (region_size != '0));

    assert_ring0_needed_R4: assert property (@(posedge clk) disable iff (rst)
        (op_allow && cls_is_gated(op_class) && !cls_is_sw_entry(op_class)) |-> (cpl == '0));

    assert_access_needed_R5: assert property (@(posedge clk) disable iff (rst)
        (op_allow && cls_is_gated(op_class) && !cls_is_sw_entry(op_class))
            |-> (cfg_acc_ctl || in_handler));

    assert_enables_needed_R6: assert property (@(posedge clk) disable iff (rst)
        (op_allow && cls_is_gated(op_class)) |-> (cfg_mode_en && cfg_feat_en));

    assert_swentry_access_R7: assert property (@(posedge clk) disable iff (rst)
        (op_allow && cls_is_sw_entry(op_class)) |-> cfg_acc_ctl);

    assert_fault_follows_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_valid && cls_is_gated(op_class) && !op_allow)) |-> op_fault);

    assert_fault_cause_R8: assert property (@(posedge clk) disable iff (rst)
        op_fault |-> $past(op_valid && cls_is_gated(op_class)));

    assert_entry_sets_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(entry_done)) |-> in_handler);

    assert_resume_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(resume_done && !entry_done)) |-> !in_handler);

    assert_idle_no_allow_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !op_allow);
endmodule

bind priv_op_gate pg_gate_checker #(.CLS_W(CLS_W), .SZ_W(SZ_W), .PL_W(PL_W)) u_gate_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_class    (op_class),
    .cpl         (cpl),
    .region_size (region_size),
    .cfg_mode_en (cfg_mode_en),
    .cfg_acc_ctl (cfg_acc_ctl),
    .cfg_feat_en (cfg_feat_en),
    .entry_done  (entry_done),
    .resume_done (resume_done),
    .op_allow    (op_allow),
    .op_fault    (op_fault),
    .in_handler  (in_handler)
);

// File: tb/test_priv_op_gate.sv
`timescale 1ns/1ps
module test_priv_op_gate;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [3:0] op_class;
    logic [1:0] cpl;
    logic [3:0] region_size;
    logic       cfg_mode_en, cfg_acc_ctl, cfg_feat_en;
    logic       entry_done, resume_done;
    logic       op_allow, op_fault, in_handler;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    priv_op_gate i_priv_op_gate (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_class (op_class),
        .cpl (cpl), .region_size (region_size), .cfg_mode_en (cfg_mode_en),
        .cfg_acc_ctl (cfg_acc_ctl), .cfg_feat_en (cfg_feat_en),
        .entry_done (entry_done), .resume_done (resume_done),
        .op_allow (op_allow), .op_fault (op_fault), .in_handler (in_handler)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (cls=%0d cpl=%0d size=%0d m=%b a=%b f=%b ih=%b)",
                     tag, what, got, exp, op_class, cpl, region_size,
                     cfg_mode_en, cfg_acc_ctl, cfg_feat_en, in_handler);
        end
    endtask

    function automatic logic exp_allow(input logic v, input int c, input int p, input int s,
                                       input logic m, input logic a, input logic f, input logic ih);
        logic base;
        if (!v) return 1'b0;
        if (c < 1 || c > 10) return 1'b1;
        base = (s != 0) && m && f;
        if (c == 7) return base && a;
        return base && (p == 0) && (a || ih);
    endfunction

    function automatic string tag_of(input int c, input int p, input int s,
                                     input logic m, input logic a, input logic f, input logic ih);
        if (c < 1 || c > 10) return "R2";
        if (c == 7) return "R7";
        if (s == 0) return "R3";
        if (!(m && f)) return "R6";
        if (p != 0) return "R4";
        return "R5";
    endfunction

    task automatic pulse(input logic en, input logic rs);
        @(negedge clk);
        entry_done = en; resume_done = rs;
        @(negedge clk);
        entry_done = 1'b0; resume_done = 1'b0;
    endtask

    initial begin
        #(4.0 * 190000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic prev_fault_exp;
        logic have_prev;
        logic e;
        rst = 1'b1; op_valid = 1'b0; op_class = '0; cpl = '0; region_size = '0;
        cfg_mode_en = 1'b0; cfg_acc_ctl = 1'b0; cfg_feat_en = 1'b0;
        entry_done = 1'b0; resume_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_handler, 1'b0, "R1", "in_handler during reset");
        chk(op_fault, 1'b0, "R1", "op_fault during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(in_handler, 1'b0, "R1", "in_handler after reset");
        chk(op_fault, 1'b0, "R1", "op_fault after reset");

        // R9 handler flag tracking
        pulse(1'b1, 1'b0);
        chk(in_handler, 1'b1, "R9", "set by entry");
        pulse(1'b0, 1'b1);
        chk(in_handler, 1'b0, "R9", "cleared by resume");
        pulse(1'b1, 1'b1);
        chk(in_handler, 1'b1, "R9", "entry wins over resume");
        pulse(1'b0, 1'b1);
        chk(in_handler, 1'b0, "R9", "cleared again");

        // R10 idle strobe: gated class with every condition failing
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (c > 0) chk(op_fault, 1'b0, "R10", "no fault for idle strobe");
            op_valid = 1'b0; op_class = 4'(c); cpl = 2'd3; region_size = '0;
            #1;
            chk(op_allow, 1'b0, "R10", "allow low without valid");
        end
        @(negedge clk);
        chk(op_fault, 1'b0, "R10", "no fault for idle strobe");

        // Exhaustive sweep, both handler states
        for (int ih = 0; ih < 2; ih++) begin
            if (ih == 1) pulse(1'b1, 1'b0);
            else         pulse(1'b0, 1'b1);
            have_prev = 1'b0;
            prev_fault_exp = 1'b0;
            for (int c = 0; c < 16; c++)
            for (int p = 0; p < 4; p++)
            for (int s = 0; s < 16; s++)
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (have_prev) chk(op_fault, prev_fault_exp, "R8", "fault pulse");
                op_valid = 1'b1; op_class = 4'(c); cpl = 2'(p); region_size = 4'(s);
                cfg_mode_en = k[0]; cfg_acc_ctl = k[1]; cfg_feat_en = k[2];
                #1;
                e = exp_allow(1'b1, c, p, s, k[0], k[1], k[2], ih[0]);
                chk(op_allow, e, tag_of(c, p, s, k[0], k[1], k[2], ih[0]), "allow");
                chk(in_handler, ih[0], "R9", "flag steady during sweep");
                prev_fault_exp = (c >= 1 && c <= 10) && !e;
                have_prev = 1'b1;
            end
            @(negedge clk);
            chk(op_fault, prev_fault_exp, "R8", "last fault pulse");
            op_valid = 1'b0;
            @(negedge clk);
            chk(op_fault, 1'b0, "R8", "fault lasts one cycle");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule